// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a small 32-bit processor that fetches, decodes, executes and retires one instruction in every clock cycle. It runs a compact instruction set: word load and store, five register-to-register operations (add, subtract, bitwise and, bitwise or, signed set-less-than), branch on equal and an absolute jump. Instruction and data storage are separate word arrays inside the core. A test environment loads them before reset is released.

Decoding happens in two levels. A main decoder turns the 6-bit opcode into a set of datapath strobes and a 2-bit arithmetic class. A second decoder turns that class and, for register-format words, the 6-bit function field into a 4-bit ALU operation. The datapath holds the program counter, a 32-entry register file, the ALU, both memories and the next-address selection. The only outputs are the current program counter and a view of the register write that the current instruction will commit at the next rising edge.

Top module: `sc_core`

## Requirements
- R1: While the synchronous reset is high, the program counter is set to 0 at each rising edge. The program counter always stays word-aligned.
- R2: Register format is opcode 0 with fields src1 [25:21], src2 [20:16], dest [15:11], unused [10:6] and func [5:0]. The func values are 0x20 add, 0x22 subtract (src1 minus src2), 0x24 and, 0x25 or. The result goes to the register named in [15:11].
- R3: Func 0x2A writes 1 when src1 is less than src2 as signed two's-complement values. Otherwise it writes 0.
- R4: Opcode 35 loads the data word at src1 plus the sign-extended immediate in [15:0]. The word index is taken from address bits above bit 1. The loaded word goes to the register named in [20:16].
- R5: Opcode 43 stores the register named in [20:16] to the address formed as in R4. It writes no register.
- R6: Opcode 4 compares src1 and src2 by subtraction. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by two. Otherwise the next PC is PC+4. It writes no register.
- R7: Opcode 2 sets the next PC to the top 4 bits of the current PC, followed by bits [25:0] of the instruction, followed by two zero bits. It writes no register.
- R8: Register 0 always reads as zero. A write aimed at it is shown on the debug port but is discarded.
- R9: Any other opcode writes nothing and advances the PC by 4.
- R10: The debug strobe, address and data describe the write that the current instruction commits at the next rising edge. The strobe is low for instructions that write no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pcOut | output | 32 | Address of the instruction now executing |
| regWeOut | output | 1 | Current instruction writes a register |
| regAddrOut | output | 5 | Destination register of that write |
| regDataOut | output | 32 | Value being written |

## Verification
Several properties are checked at every cycle: the reset value and word alignment of the program counter, the exact next address after sequential instructions, after taken branches and after jumps, and that a store never raises a register write. Other behaviours show up only in the bench's programs, run across a sweep of operand pairs that includes equal, signed-boundary and mixed-sign values. These are the arithmetic results, the signed compare, a store followed by a reload at a negative offset, the discarding of writes to register 0, the choice between branch paths and unknown opcodes acting as no-ops.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int XLEN = 32;
  localparam int REG_ADDR_W = 5;
  localparam int NUM_REGS = 1 << REG_ADDR_W;

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_JUMP  = 6'd2;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_LOAD  = 6'd35;
  localparam logic [5:0] OP_STORE = 6'd43;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  localparam logic [1:0] CLASS_ADD  = 2'b00;
  localparam logic [1:0] CLASS_SUB  = 2'b01;
  localparam logic [1:0] CLASS_FUNC = 2'b10;

  localparam logic [3:0] ALU_AND = 4'b0000;
  localparam logic [3:0] ALU_OR  = 4'b0001;
  localparam logic [3:0] ALU_ADD = 4'b0010;
  localparam logic [3:0] ALU_SUB = 4'b0110;
  localparam logic [3:0] ALU_SLT = 4'b0111;

  typedef struct packed {
    logic       regWrite;
    logic       regDstRd;
    logic       aluSrcImm;
    logic       memWrite;
    logic       memToReg;
    logic       branch;
    logic       jump;
    logic [1:0] aluClass;
    logic [3:0] aluCtl;
  } ctrl_t;

endpackage

// File: rtl/sc_control.sv
module sc_control
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  ctrl_t mainDec;

  always_comb begin
    mainDec = '0;
    unique case (opcode)
      OP_RTYPE: begin
        mainDec.regWrite = 1'b1;
        mainDec.regDstRd = 1'b1;
        mainDec.aluClass = CLASS_FUNC;
      end
      OP_LOAD: begin
        mainDec.regWrite  = 1'b1;
        mainDec.aluSrcImm = 1'b1;
        mainDec.memToReg  = 1'b1;
        mainDec.aluClass  = CLASS_ADD;
      end
      OP_STORE: begin
        mainDec.aluSrcImm = 1'b1;
        mainDec.memWrite  = 1'b1;
        mainDec.aluClass  = CLASS_ADD;
      end
      OP_BEQ: begin
        mainDec.branch   = 1'b1;
        mainDec.aluClass = CLASS_SUB;
      end
      OP_JUMP: mainDec.jump = 1'b1;
      default: mainDec = '0;
    endcase
  end

  always_comb begin
    ctrl = mainDec;
    case (mainDec.aluClass)
      CLASS_ADD: ctrl.aluCtl = ALU_ADD;
      CLASS_SUB: ctrl.aluCtl = ALU_SUB;
      CLASS_FUNC: begin
        case (funct)
          FN_ADD:  ctrl.aluCtl = ALU_ADD;
          FN_SUB:  ctrl.aluCtl = ALU_SUB;
          FN_AND:  ctrl.aluCtl = ALU_AND;
          FN_OR:   ctrl.aluCtl = ALU_OR;
          FN_SLT:  ctrl.aluCtl = ALU_SLT;
          default: ctrl.aluCtl = ALU_AND;
        endcase
      end
      default: ctrl.aluCtl = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  logic [3:0]      aluCtl,
  output logic [XLEN-1:0] result,
  output logic            zero
);

  always_comb begin
    case (aluCtl)
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_ADD: result = opA + opB;
      ALU_SUB: result = opA - opB;
      ALU_SLT: result = {{(XLEN-1){1'b0}}, ($signed(opA) < $signed(opB))};
      default: result = '0;
    endcase
  end

  assign zero = (result == '0);

endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ctrl_t                 ctrl,
  output logic [5:0]            opcode,
  output logic [5:0]            funct,
  output logic [XLEN-1:0]       pcOut,
  output logic                  regWeOut,
  output logic [REG_ADDR_W-1:0] regAddrOut,
  output logic [XLEN-1:0]       regDataOut
);

  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  logic [XLEN-1:0] instrMem [IMEM_WORDS];
  logic [XLEN-1:0] dataMem  [DMEM_WORDS];
  logic [XLEN-1:0] regFile  [NUM_REGS];

  logic [XLEN-1:0] pcReg, pcPlus4, brTarget, jmpTarget, nextPc;
  logic [XLEN-1:0] instr, simm, rsData, rtData, aluB, aluRes, memRdata, wbData;
  logic [REG_ADDR_W-1:0] rsAddr, rtAddr, rdAddr, wbAddr;
  logic aluZero;
  logic unusedBits;

  initial begin
    for (int i = 0; i < IMEM_WORDS; i++) instrMem[i] = '0;
  end

  assign instr  = instrMem[pcReg[IAW+1:2]];
  assign opcode = instr[31:26];
  assign funct  = instr[5:0];
  assign rsAddr = instr[25:21];
  assign rtAddr = instr[20:16];
  assign rdAddr = instr[15:11];
  assign simm   = {{(XLEN-16){instr[15]}}, instr[15:0]};

  assign rsData = (rsAddr == '0) ? '0 : regFile[rsAddr];
  assign rtData = (rtAddr == '0) ? '0 : regFile[rtAddr];
  assign aluB   = ctrl.aluSrcImm ? simm : rtData;

  sc_alu alu_i (
    .opA    (rsData),
    .opB    (aluB),
    .aluCtl (ctrl.aluCtl),
    .result (aluRes),
    .zero   (aluZero)
  );

  assign memRdata = dataMem[aluRes[DAW+1:2]];
  assign wbData   = ctrl.memToReg ? memRdata : aluRes;
  assign wbAddr   = ctrl.regDstRd ? rdAddr : rtAddr;

  always_ff @(posedge clk) begin
    if (ctrl.regWrite && wbAddr != '0) regFile[wbAddr] <= wbData;
  end

  always_ff @(posedge clk) begin
    if (ctrl.memWrite) dataMem[aluRes[DAW+1:2]] <= rtData;
  end

  assign pcPlus4   = pcReg + 32'd4;
  assign brTarget  = pcPlus4 + {simm[XLEN-3:0], 2'b00};
  assign jmpTarget = {pcReg[31:28], instr[25:0], 2'b00};

  always_comb begin
    if (ctrl.jump)                   nextPc = jmpTarget;
    else if (ctrl.branch && aluZero) nextPc = brTarget;
    else                             nextPc = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pcReg <= '0;
    else     pcReg <= nextPc;
  end

  assign pcOut      = pcReg;
  assign regWeOut   = ctrl.regWrite;
  assign regAddrOut = wbAddr;
  assign regDataOut = wbData;

  assign unusedBits = ^{instr[10:6], aluRes[XLEN-1:DAW+2], aluRes[1:0], ctrl.aluClass};

  AST_RESET_PC: assert property (@(posedge clk) rst |=> pcReg == '0); // R1
  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst) pcReg[1:0] == 2'b00); // R1
  AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.jump && !(ctrl.branch && aluZero)) |=> pcReg == $past(pcReg) + 32'd4); // R9
  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
    (ctrl.branch && aluZero) |=> pcReg == $past(pcReg) + 32'd4 + ($past(simm) << 2)); // R6
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    ctrl.jump |=> (pcReg[31:28] == $past(pcReg[31:28])) && (pcReg[27:2] == $past(instr[25:0]))); // R7
  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
    ctrl.memWrite |-> !ctrl.regWrite); // R5

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] pcOut,
  output logic        regWeOut,
  output logic [4:0]  regAddrOut,
  output logic [31:0] regDataOut
);

  ctrl_t ctrl;
  logic [5:0] opcode, funct;

  sc_control ctrl_i (
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrl)
  );

  sc_datapath #(
    .IMEM_WORDS (IMEM_WORDS),
    .DMEM_WORDS (DMEM_WORDS)
  ) dpath_i (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .opcode     (opcode),
    .funct      (funct),
    .pcOut      (pcOut),
    .regWeOut   (regWeOut),
    .regAddrOut (regAddrOut),
    .regDataOut (regDataOut)
  );

endmodule

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] pcOut, regDataOut;
  logic regWeOut;
  logic [4:0] regAddrOut;
  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sc_core dut_i (
    .clk(clk), .rst(rst), .pcOut(pcOut), .regWeOut(regWeOut),
    .regAddrOut(regAddrOut), .regDataOut(regDataOut)
  );

  function automatic logic [31:0] encR(int rs, int rt, int rd, logic [5:0] fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] encI(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // at a negedge: check the instruction at word idx and its write view, then advance
  task automatic step(int idx, bit we, int a, logic [31:0] d, string req);
    check({req, " pc"}, pcOut, idx * 4);
    check({req, " we"}, {31'd0, regWeOut}, {31'd0, we});
    if (we) begin
      check({req, " addr"}, {27'd0, regAddrOut}, a);
      check({req, " data"}, regDataOut, d);
    end
    @(negedge clk);
  endtask

  task automatic runTrial(logic [31:0] a, logic [31:0] b);
    logic [31:0] slt;
    slt = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    rst = 1'b1;
    dut_i.dpath_i.dataMem[0] <= a;
    dut_i.dpath_i.dataMem[1] <= b;
    dut_i.dpath_i.dataMem[2] <= 32'd44;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset pc", pcOut, 32'd0);
    rst = 1'b0;
    step(0, 1, 1, a, "R4 lw a");
    step(1, 1, 2, b, "R4 lw b");
    step(2, 1, 3, a + b, "R2 add");
    step(3, 1, 4, a - b, "R2 sub");
    step(4, 1, 5, a & b, "R2 and");
    step(5, 1, 6, a | b, "R2 or");
    step(6, 1, 7, slt, "R3 slt");
    step(7, 0, 0, 0, "R5 sw");
    step(8, 1, 8, a + b, "R5 reload");
    step(9, 1, 0, a + b, "R10 write to r0 shown");
    step(10, 1, 9, 32'd0, "R8 r0 reads zero");
    step(11, 0, 0, 0, "R6 beq taken");
    step(13, 0, 0, 0, "R6 beq compare");
    if (a != b) begin
      step(14, 1, 10, a + b, "R6 not taken path");
      step(15, 0, 0, 0, "R7 jump");
    end else begin
      step(16, 0, 0, 0, "R9 unknown opcode");
    end
    step(17, 1, 13, 32'd44, "R4 base load");
    step(18, 1, 12, a + b, "R4 negative offset");
    step(19, 0, 0, 0, "R6 backward branch");
    step(19, 0, 0, 0, "R6 self loop");
  endtask

  initial begin
    #1;
    dut_i.dpath_i.instrMem[0]  = encI(6'd35, 0, 1, 16'd0);
    dut_i.dpath_i.instrMem[1]  = encI(6'd35, 0, 2, 16'd4);
    dut_i.dpath_i.instrMem[2]  = encR(1, 2, 3, 6'h20);
    dut_i.dpath_i.instrMem[3]  = encR(1, 2, 4, 6'h22);
    dut_i.dpath_i.instrMem[4]  = encR(1, 2, 5, 6'h24);
    dut_i.dpath_i.instrMem[5]  = encR(1, 2, 6, 6'h25);
    dut_i.dpath_i.instrMem[6]  = encR(1, 2, 7, 6'h2A);
    dut_i.dpath_i.instrMem[7]  = encI(6'd43, 0, 3, 16'd32);
    dut_i.dpath_i.instrMem[8]  = encI(6'd35, 0, 8, 16'd32);
    dut_i.dpath_i.instrMem[9]  = encR(1, 2, 0, 6'h20);
    dut_i.dpath_i.instrMem[10] = encR(0, 0, 9, 6'h20);
    dut_i.dpath_i.instrMem[11] = encI(6'd4, 1, 1, 16'd1);
    dut_i.dpath_i.instrMem[12] = encR(1, 1, 10, 6'h20);
    dut_i.dpath_i.instrMem[13] = encI(6'd4, 1, 2, 16'd2);
    dut_i.dpath_i.instrMem[14] = encR(2, 1, 10, 6'h20);
    dut_i.dpath_i.instrMem[15] = {6'd2, 26'd17};
    dut_i.dpath_i.instrMem[16] = 32'hFFFF_FFFF;
    dut_i.dpath_i.instrMem[17] = encI(6'd35, 0, 13, 16'd8);
    dut_i.dpath_i.instrMem[18] = encI(6'd35, 13, 12, 16'hFFF4);
    dut_i.dpath_i.instrMem[19] = encI(6'd4, 0, 0, 16'hFFFF);
    @(negedge clk);
    runTrial(32'd5, 32'd3);
    runTrial(32'd3, 32'd5);
    runTrial(32'd7, 32'd7);
    runTrial(32'hFFFF_FFFF, 32'd1);
    runTrial(32'h8000_0000, 32'h7FFF_FFFF);
    runTrial(32'hFFFF_0000, 32'h00FF_00FF);
    runTrial(32'd0, 32'd0);
    runTrial(32'd1, 32'hFFFF_FFFF);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule